// File: doc/BRIEF.md
# Page Translation Cache

This block keeps the most recent virtual-to-physical page translations in a small array in which every entry is compared at once. A lookup presents a virtual address and, one clock later, receives a hit flag, the translated physical address, the two access-permission bits and the cacheable and bufferable flags of the page. When a lookup misses while translation is on, the block raises a request for the page-table walker. The walker is a separate block. It writes its result back through the refill port.

Pages are 64 KB by default. The upper address bits form the virtual page number (VPN). The lower bits pass through unchanged. When translation is off, the block maps addresses flat. A flush input clears every entry at once, so that a context switch leaves no stale mapping that can still hit.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, and `res_valid`, `res_hit` and `walk_req` are low.
- R2: A lookup sampled at a clock edge (`lk_valid` high) shows its result on the registered outputs after that same edge, with `res_valid` high. It is judged against the entry contents held before that edge. In a cycle without a lookup, `res_valid`, `res_hit` and `walk_req` are low after the edge.
- R3: On a hit with translation on, `res_paddr` is the stored frame number in bits [31:16] and the lookup address bits [15:0] in bits [15:0]. `res_perm`, `res_cache` and `res_buf` are the values stored with that entry.
- R4: A lookup with translation on that matches no valid entry gives `res_hit` = 0 and `walk_req` = 1. `walk_req` is never high without a completed missing lookup.
- R5: With `xlat_en` low a lookup returns `res_hit` = 1, `res_paddr` equal to the lookup address, `res_perm` = 2'b11, `res_cache` = 0, `res_buf` = 0 and `walk_req` = 0, whatever the entries hold.
- R6: A flush invalidates all entries. Every later lookup with translation on misses until a refill.
- R7: A refill whose VPN is already held overwrites that entry. Otherwise it takes the lowest-numbered invalid entry.
- R8: A refill into a full array with a new VPN replaces the entry under a round-robin pointer. The pointer is 0 after reset, moves up by one after each such replacement and wraps from 63 to 0. A flush leaves the pointer unchanged.
- R9: When a flush and a refill arrive in the same cycle, the flush wins and the refill is dropped.
- R10: At most one valid entry ever matches a given VPN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation on (1) or flat mapping (0) |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Lookup virtual address |
| fill_en | input | 1 | Write a new translation |
| fill_vpn | input | 16 | Virtual page number of the refill |
| fill_pfn | input | 16 | Physical frame number of the refill |
| fill_perm | input | 2 | Access-permission bits of the refill |
| fill_cache | input | 1 | Cacheable flag of the refill |
| fill_buf | input | 1 | Bufferable flag of the refill |
| flush | input | 1 | Invalidate all entries |
| res_valid | output | 1 | Registered lookup result present |
| res_hit | output | 1 | Lookup hit (always 1 in flat mode) |
| res_paddr | output | 32 | Physical address |
| res_perm | output | 2 | Access-permission bits |
| res_cache | output | 1 | Cacheable flag |
| res_buf | output | 1 | Bufferable flag |
| walk_req | output | 1 | Miss: table walk needed |

## Verification
The assertions check several rules on every cycle: that no VPN ever matches two entries, that a walk request only comes with a missing result, that flat mode and the pass-through of the page offset hold for every lookup, and that a flush, even one that meets a refill, leaves the array empty. Only the bench scenarios can show the rest. These are the placement order of refills, the round-robin eviction once all 64 entries are full, and the exact frame number and attributes returned after overwrites. They also include lookups that meet a refill or a flush in the same cycle and still see the old contents.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int PERM_W = 2;

    typedef struct packed {
        logic [PERM_W-1:0] perm;
        logic              cacheable;
        logic              bufferable;
    } page_attr_t;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
    parameter int N     = 64,
    parameter int TAG_W = 16,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              valid,
    input  logic [N-1:0][TAG_W-1:0]   tags,
    input  logic [TAG_W-1:0]          key,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

    // R10: entries never alias a page
    a_r10_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N = 64,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     valid,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic             free_found,
    output logic [IDX_W-1:0] pick_idx
);
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        free_idx = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign free_found = ~&valid;
    assign pick_idx   = free_found ? free_idx : rr_ptr;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int ADDR_W  = 32,
    parameter int PAGE_W  = 16,
    parameter int ENTRIES = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         xlat_en,
    input  logic                         lk_valid,
    input  logic [ADDR_W-1:0]            lk_vaddr,
    input  logic                         fill_en,
    input  logic [ADDR_W-PAGE_W-1:0]     fill_vpn,
    input  logic [ADDR_W-PAGE_W-1:0]     fill_pfn,
    input  logic [xlat_pkg::PERM_W-1:0]  fill_perm,
    input  logic                         fill_cache,
    input  logic                         fill_buf,
    input  logic                         flush,
    output logic                         res_valid,
    output logic                         res_hit,
    output logic [ADDR_W-1:0]            res_paddr,
    output logic [xlat_pkg::PERM_W-1:0]  res_perm,
    output logic                         res_cache,
    output logic                         res_buf,
    output logic                         walk_req
);
    import xlat_pkg::*;

    localparam int VPN_W = ADDR_W - PAGE_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][VPN_W-1:0]  vpn;
        logic [ENTRIES-1:0][VPN_W-1:0]  pfn;
        page_attr_t [ENTRIES-1:0]       attr;
        logic [IDX_W-1:0]               rr;
        logic                           res_valid;
        logic                           res_hit;
        logic [ADDR_W-1:0]              res_paddr;
        page_attr_t                     res_attr;
        logic                           walk;
    } state_t;

    state_t st_d, st_q;

    logic             lk_hit, fl_hit, free_found;
    logic [IDX_W-1:0] lk_idx, fl_idx, pick_idx, slot;

    xlat_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
        .clk(clk), .rst_n(rst_n), .valid(st_q.valid), .tags(st_q.vpn),
        .key(lk_vaddr[ADDR_W-1:PAGE_W]), .hit(lk_hit), .hit_idx(lk_idx)
    );

    xlat_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fl_match (
        .clk(clk), .rst_n(rst_n), .valid(st_q.valid), .tags(st_q.vpn),
        .key(fill_vpn), .hit(fl_hit), .hit_idx(fl_idx)
    );

    xlat_victim #(.N(ENTRIES)) u_victim (
        .valid(st_q.valid), .rr_ptr(st_q.rr),
        .free_found(free_found), .pick_idx(pick_idx)
    );

    assign slot = fl_hit ? fl_idx : pick_idx;

    always_comb begin
        st_d = st_q;
        // lookup against current contents
        st_d.res_valid = lk_valid;
        st_d.res_hit   = 1'b0;
        st_d.walk      = 1'b0;
        if (lk_valid) begin
            if (!xlat_en) begin
                st_d.res_hit   = 1'b1;
                st_d.res_paddr = lk_vaddr;
                st_d.res_attr  = '{perm: '1, cacheable: 1'b0, bufferable: 1'b0};
            end else if (lk_hit) begin
                st_d.res_hit   = 1'b1;
                st_d.res_paddr = {st_q.pfn[lk_idx], lk_vaddr[PAGE_W-1:0]};
                st_d.res_attr  = st_q.attr[lk_idx];
            end else begin
                st_d.walk = 1'b1;
            end
        end
        // maintenance: flush beats refill
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_en) begin
            st_d.valid[slot] = 1'b1;
            st_d.vpn[slot]   = fill_vpn;
            st_d.pfn[slot]   = fill_pfn;
            st_d.attr[slot]  = '{perm: fill_perm, cacheable: fill_cache,
                                 bufferable: fill_buf};
            if (!fl_hit && !free_found) begin
                st_d.rr = (st_q.rr == IDX_W'(ENTRIES-1)) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_valid;
    assign res_hit   = st_q.res_hit;
    assign res_paddr = st_q.res_paddr;
    assign res_perm  = st_q.res_attr.perm;
    assign res_cache = st_q.res_attr.cacheable;
    assign res_buf   = st_q.res_attr.bufferable;
    assign walk_req  = st_q.walk;

    // R4: walk requested only for a missing, completed lookup
    a_r4_walk_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> (res_valid && !res_hit));

    // R5: flat mapping when translation is off
    a_r5_bypass_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !xlat_en) |=> (res_hit && !walk_req && res_paddr == $past(lk_vaddr)));

    // R3: page offset passes through untouched on a hit
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!res_hit || res_paddr[PAGE_W-1:0] == $past(lk_vaddr[PAGE_W-1:0])));

    // R6 / R9: flush empties the array even against a refill
    a_r9_flush_wins: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.valid == '0));

    // R7: a refill without flush leaves a valid entry
    a_r7_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush) |=> (st_q.valid != '0));

    // R2: result strobe follows the request by one edge
    a_r2_result_timing: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);
endmodule

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0, lk_valid = 1'b0, fill_en = 1'b0, flush = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [15:0] fill_vpn = '0, fill_pfn = '0;
    logic [1:0]  fill_perm = '0;
    logic        fill_cache = 1'b0, fill_buf = 1'b0;
    logic        res_valid, res_hit, res_cache, res_buf, walk_req;
    logic [31:0] res_paddr;
    logic [1:0]  res_perm;

    int n_tests = 0;
    int n_fail  = 0;

    // model state
    logic        m_valid [N];
    logic [15:0] m_vpn   [N];
    logic [15:0] m_pfn   [N];
    logic [3:0]  m_attr  [N];
    int          m_rr;

    // expected result
    logic        e_valid, e_hit, e_walk;
    logic [31:0] e_paddr;
    logic [3:0]  e_attr;

    always #10 clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .lk_valid(lk_valid),
        .lk_vaddr(lk_vaddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_cache(fill_cache),
        .fill_buf(fill_buf), .flush(flush), .res_valid(res_valid),
        .res_hit(res_hit), .res_paddr(res_paddr), .res_perm(res_perm),
        .res_cache(res_cache), .res_buf(res_buf), .walk_req(walk_req)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_attr[i] = '0;
        end
        m_rr = 0;
    endfunction

    function automatic void model_lookup(logic lv, logic en, logic [31:0] va);
        e_valid = lv; e_hit = 1'b0; e_walk = 1'b0; e_paddr = '0; e_attr = '0;
        if (lv) begin
            if (!en) begin
                e_hit = 1'b1; e_paddr = va; e_attr = 4'b1100;
            end else begin
                for (int i = 0; i < N; i++) begin
                    if (m_valid[i] && m_vpn[i] == va[31:16]) begin
                        e_hit = 1'b1; e_paddr = {m_pfn[i], va[15:0]}; e_attr = m_attr[i];
                    end
                end
                e_walk = !e_hit;
            end
        end
    endfunction

    function automatic void model_update(logic fe, logic fl, logic [15:0] vpn,
                                         logic [15:0] pfn, logic [3:0] attr);
        int slot;
        if (fl) begin
            for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        end else if (fe) begin
            slot = -1;
            for (int i = 0; i < N; i++)
                if (slot < 0 && m_valid[i] && m_vpn[i] == vpn) slot = i;
            for (int i = 0; i < N; i++)
                if (slot < 0 && !m_valid[i]) slot = i;
            if (slot < 0) begin
                slot = m_rr;
                m_rr = (m_rr + 1) % N;
            end
            m_valid[slot] = 1'b1; m_vpn[slot] = vpn; m_pfn[slot] = pfn; m_attr[slot] = attr;
        end
    endfunction

    // one cycle: drive, clock, compare against the model
    task automatic step(string req, logic lv, logic en, logic [31:0] va,
                        logic fe, logic fl, logic [15:0] vpn, logic [15:0] pfn,
                        logic [3:0] attr);
        lk_valid = lv; xlat_en = en; lk_vaddr = va;
        fill_en = fe; flush = fl; fill_vpn = vpn; fill_pfn = pfn;
        fill_perm = attr[3:2]; fill_cache = attr[1]; fill_buf = attr[0];
        model_lookup(lv, en, va);
        model_update(fe, fl, vpn, pfn, attr);
        @(posedge clk);
        @(negedge clk);
        check(req, "res_valid", {31'b0, res_valid}, {31'b0, e_valid});
        check(req, "res_hit",   {31'b0, res_hit},   {31'b0, e_hit});
        check(req, "walk_req",  {31'b0, walk_req},  {31'b0, e_walk});
        if (e_hit) begin
            check(req, "res_paddr", res_paddr, e_paddr);
            check(req, "attr", {28'b0, res_perm, res_cache, res_buf}, {28'b0, e_attr});
        end
    endtask

    task automatic look(string req, logic en, logic [31:0] va);
        step(req, 1'b1, en, va, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic fill(string req, logic [15:0] vpn, logic [15:0] pfn, logic [3:0] attr);
        step(req, 1'b0, 1'b1, '0, 1'b1, 1'b0, vpn, pfn, attr);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0017));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "res_valid", {31'b0, res_valid}, 32'd0);
        check("R1", "res_hit",   {31'b0, res_hit},   32'd0);
        check("R1", "walk_req",  {31'b0, walk_req},  32'd0);
        look("R1", 1'b1, 32'h1234_5678);            // R4: empty array misses
        look("R4", 1'b1, 32'h0000_0000);
        fill("R7", 16'h1234, 16'hABCD, 4'b1010);
        look("R3", 1'b1, 32'h1234_5678);
        check("R3", "paddr direct", res_paddr, 32'hABCD_5678);
        look("R5", 1'b0, 32'hDEAD_BEEF);
        check("R5", "perm flat", {30'b0, res_perm}, 32'd3);
        step("R2", 1'b0, 1'b1, 32'h1234_0000, 1'b0, 1'b0, '0, '0, '0);
        fill("R7", 16'h1234, 16'h0F0F, 4'b0111);    // overwrite same VPN
        look("R7", 1'b1, 32'h1234_0001);
        // R11-like ordering: lookup in same cycle as refill sees old contents (R2)
        step("R2", 1'b1, 1'b1, 32'h7777_0004, 1'b1, 1'b0, 16'h7777, 16'h1111, 4'b0001);
        look("R2", 1'b1, 32'h7777_0004);
        // lookup together with flush still hits old contents (R2), then misses (R6)
        step("R2", 1'b1, 1'b1, 32'h7777_0008, 1'b0, 1'b1, '0, '0, '0);
        look("R6", 1'b1, 32'h7777_0008);
        look("R6", 1'b1, 32'h1234_5678);
        // R9: flush and refill together
        step("R9", 1'b0, 1'b1, '0, 1'b1, 1'b1, 16'h4444, 16'h5555, 4'b1111);
        look("R9", 1'b1, 32'h4444_0000);
        // R8: fill all entries, then evict in round-robin order
        for (int i = 0; i < N; i++) fill("R7", 16'h0100 + 16'(i), 16'h8000 + 16'(i), 4'b0100);
        for (int i = 0; i < N; i++) look("R7", 1'b1, {16'h0100 + 16'(i), 16'h0042});
        fill("R8", 16'h0200, 16'h9000, 4'b1000);
        look("R8", 1'b1, 32'h0100_0000);
        look("R8", 1'b1, 32'h0101_0000);
        fill("R8", 16'h0201, 16'h9001, 4'b1000);
        look("R8", 1'b1, 32'h0101_0000);
        look("R8", 1'b1, 32'h0102_0000);
        look("R8", 1'b1, 32'h0200_0010);
        // random mix, R10 kept by assertion throughout
        for (int k = 0; k < 3000; k++) begin
            logic        lv, en, fe, fl;
            logic [15:0] vpn, pfn;
            logic [31:0] va;
            lv  = ($urandom % 4) != 0;
            en  = ($urandom % 10) != 0;
            fe  = ($urandom % 3) == 0;
            fl  = ($urandom % 150) == 0;
            vpn = 16'h0300 + 16'($urandom % 80);
            pfn = 16'($urandom);
            va  = {16'h0300 + 16'($urandom % 80), 16'($urandom)};
            step("R10", lv, en, va, fe, fl, vpn, pfn, 4'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule